// File: doc/BRIEF.md
# Quad SPI Execute-in-Place Read Engine

This block sits between an on-chip read bus and a serial NOR flash wired with four data lines. It works in one of two modes. In command mode, software writes a small register set and each write of the command word launches a single framed transfer to the flash. In memory mode, every bus read becomes one flash read frame, and the bus waits until the read data has been shifted in.

Each frame is made of up to five phases: an opcode sent serially on line 0, an address of three or four bytes, an optional intermediate (mode) byte, a programmable number of dummy clocks and, for memory reads only, the data. The address, the intermediate byte and the data all use the four lines. The block supports the flash's continuous-read mode, in which no opcode is sent. Software first issues one command frame that carries the opcode and the intermediate value 0xA5, with a zero address allowed and no data. It polls the busy flag until that frame is done. It then writes the memory-command word with the opcode-omit flag set. From then on every memory read saves the eight serial clocks of the opcode.

Top module: `qspi_xip_rd`

## Requirements
- R1: A frame sends its phases in this order: opcode, address, intermediate byte, dummy clocks, data. The opcode goes out on io_out[0] over 8 serial clocks, most significant bit first, with io_oe = 4'b0001. The address and the intermediate byte go out on all four lines, high nibble first, with io_oe = 4'b1111.
- R2: Command and memory-command words share one layout: bits [7:0] are the opcode, bit 8 selects a 4-byte address (otherwise the low 24 address bits are sent in 6 serial clocks), bit 9 omits the opcode phase, and bit 10 enables the intermediate byte.
- R3: A frame with bit 9 set carries no opcode phase and is exactly 8 serial clocks shorter than the same frame with the opcode.
- R4: The intermediate byte comes from register 1 bits [7:0]. The dummy clock count comes from register 2 bits [DUMMY_W-1:0]. A count of zero removes the dummy phase.
- R5: Writing register 3 starts one command frame, which uses the address in register 0 and has no data phase. Status bit 1 (register 5) reads 1 from the cycle after the write until that frame and its deselect gap have ended.
- R6: Writing register 4 sets status bit 0 and enters memory mode. While it is set, each held mem_req produces one frame that reads DATA_W/4 nibbles. mem_ready then pulses for one cycle with mem_rdata assembled little-endian: the first byte received lands in bits [7:0], and within each byte the first nibble is the high nibble.
- R7: mem_ready stays low until the frame's last data nibble has been sampled, and is only raised with chip select released.
- R8: sck runs at half the clk rate, and the flash samples it on the rising edge. sck is low whenever cs_n is high. cs_n stays high for at least one serial clock (two clk cycles) between frames.
- R9: A command write that arrives during a memory-mode frame lets that frame finish and deliver its data. The command frame runs afterwards. Status bit 0 is cleared by the command write.
- R10: Writing register 5 with bit 4 set requests a reset. Any running frame is aborted, and cs_n goes high on the next clock edge. Bit 4 reads 1 until the sequencer is idle, after which status bits 0, 1 and 4 read 0.
- R11: After the priming command frame (opcode present, intermediate byte 0xA5), opcode-less memory reads return the correct flash data at 3- and 4-byte addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 address, 1 intermediate, 2 control, 3 command, 4 memory command, 5 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | input | 1 | Bus read request, held until mem_ready |
| mem_addr | input | 32 | Bus read byte address |
| mem_rdata | output | DATA_W | Bus read data |
| mem_ready | output | 1 | One-cycle completion pulse for a bus read |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low flash select |
| io_out | output | 4 | Data lines driven to the flash |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Data lines from the flash |

## Verification
The assertions watch the pin-level rules on every cycle: sck is quiet while deselected, the deselect gap has its minimum length, a reset request releases chip select at once, mem_ready is a single pulse issued after chip select is released, and leaving reset clears memory mode. The correctness of the frame contents only shows up through the bench's scenarios, which use a behavioural flash that decodes opcode, address and intermediate byte and answers with data. This covers the opcode-less mode after priming, the frame lengths for 3- and 4-byte addresses with and without dummy clocks, the ordering of a command write that lands mid-frame, and the status sequence around a reset request.

// File: rtl/qxr_pkg.sv
package qxr_pkg;
   typedef enum logic [2:0] {
      PH_IDLE, PH_OPC, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA, PH_GAP
   } qxr_phase_e;

   // Layout of the command and memory-command words (bits 10..0)
   typedef struct packed {
      logic       mode_en;
      logic       no_opc;
      logic       addr4;
      logic [7:0] opc;
   } qxr_fmt_t;

   localparam logic [2:0] SEL_ADDR = 3'd0;
   localparam logic [2:0] SEL_MODE = 3'd1;
   localparam logic [2:0] SEL_CTRL = 3'd2;
   localparam logic [2:0] SEL_CMD  = 3'd3;
   localparam logic [2:0] SEL_MEM  = 3'd4;
   localparam logic [2:0] SEL_STAT = 3'd5;

   localparam int STAT_MINIT = 0;
   localparam int STAT_CBUSY = 1;
   localparam int STAT_RREQ  = 4;
endpackage

// File: rtl/qxr_regs.sv
module qxr_regs
   import qxr_pkg::*;
#(
   parameter int DUMMY_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [2:0]         reg_sel,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               seq_busy,
   input  logic               seq_cmd_act,
   output logic               cmd_go,
   output logic               cmd_wait,
   output qxr_fmt_t           cmd_fmt,
   output qxr_fmt_t           mem_fmt,
   output logic [31:0]        cmd_addr,
   output logic [7:0]         mode_byte,
   output logic [DUMMY_W-1:0] dummy,
   output logic               mem_mode,
   output logic               abort
);
   logic rst_req, cmd_pend, mcinit;
   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[31:11];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_req   <= 1'b0;
         cmd_pend  <= 1'b0;
         mcinit    <= 1'b0;
         cmd_fmt   <= '0;
         mem_fmt   <= '0;
         cmd_addr  <= '0;
         mode_byte <= '0;
         dummy     <= '0;
      end else if (rst_req) begin
         mcinit   <= 1'b0;
         cmd_pend <= 1'b0;
         if (!seq_busy) rst_req <= 1'b0;
      end else begin
         if (cmd_go) cmd_pend <= 1'b0;
         if (reg_wr) begin
            case (reg_sel)
               SEL_ADDR: cmd_addr  <= reg_wdata;
               SEL_MODE: mode_byte <= reg_wdata[7:0];
               SEL_CTRL: dummy     <= reg_wdata[DUMMY_W-1:0];
               SEL_CMD: begin
                  cmd_fmt  <= reg_wdata[10:0];
                  cmd_pend <= 1'b1;
                  mcinit   <= 1'b0;
               end
               SEL_MEM: begin
                  mem_fmt <= reg_wdata[10:0];
                  mcinit  <= 1'b1;
               end
               SEL_STAT: if (reg_wdata[STAT_RREQ]) rst_req <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign cmd_go   = cmd_pend && !seq_busy && !rst_req;
   assign cmd_wait = cmd_pend;
   assign mem_mode = mcinit;
   assign abort    = rst_req;

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_ADDR: reg_rdata = cmd_addr;
         SEL_MODE: reg_rdata[7:0] = mode_byte;
         SEL_CTRL: reg_rdata[DUMMY_W-1:0] = dummy;
         SEL_CMD:  reg_rdata[10:0] = cmd_fmt;
         SEL_MEM:  reg_rdata[10:0] = mem_fmt;
         SEL_STAT: begin
            reg_rdata[STAT_MINIT] = mcinit;
            reg_rdata[STAT_CBUSY] = cmd_pend | seq_cmd_act;
            reg_rdata[STAT_RREQ]  = rst_req;
         end
         default: ;
      endcase
   end

   AST_RST_EXIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_req) |-> (!mcinit && !cmd_pend)) else $error("reset exit"); // R10
   AST_MEMCMD_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_MEM && !rst_req) |=> mcinit) else $error("memcmd"); // R6
   AST_CMD_LEAVES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_CMD) |=> !mcinit) else $error("cmd write"); // R9
endmodule

// File: rtl/qxr_seq.sv
module qxr_seq
   import qxr_pkg::*;
#(
   parameter int DUMMY_W    = 4,
   parameter int DATA_W     = 32,
   parameter bit LITTLE_END = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go_cmd,
   input  logic               go_mem,
   input  qxr_fmt_t           cmd_fmt,
   input  qxr_fmt_t           mem_fmt,
   input  logic [31:0]        cmd_addr,
   input  logic [31:0]        mem_addr,
   input  logic [7:0]         mode_byte,
   input  logic [DUMMY_W-1:0] dummy,
   input  logic               abort,
   input  logic [3:0]         io_in,
   output logic               busy,
   output logic               cmd_act,
   output logic               mem_ready,
   output logic [DATA_W-1:0]  mem_rdata,
   output logic               sck,
   output logic               cs_n,
   output logic [3:0]         io_out,
   output logic [3:0]         io_oe
);
   localparam int NIB   = DATA_W / 4;
   localparam int CNT_W = DUMMY_W + 5;

   qxr_phase_e       ph, ph_nxt, ph_after_mode, ph_after_addr;
   logic             half, is_mem, addr4_q, mode_en_q, act, last;
   logic [CNT_W-1:0] cnt, len;
   logic [7:0]       opc_sh, mod_sh;
   logic [31:0]      adr_sh;
   logic [DATA_W-5:0] dat;
   logic [DATA_W-1:0] raw_next, ordered;
   qxr_fmt_t         st_fmt;
   logic [31:0]      st_addr;

   assign st_fmt  = go_cmd ? cmd_fmt : mem_fmt;
   assign st_addr = go_cmd ? cmd_addr : mem_addr;

   always_comb begin
      case (ph)
         PH_OPC:   len = CNT_W'(8);
         PH_ADDR:  len = addr4_q ? CNT_W'(8) : CNT_W'(6);
         PH_MODE:  len = CNT_W'(2);
         PH_DUMMY: len = CNT_W'(dummy);
         PH_DATA:  len = CNT_W'(NIB);
         default:  len = CNT_W'(1);
      endcase
   end

   assign ph_after_mode = (dummy != '0) ? PH_DUMMY : (is_mem ? PH_DATA : PH_GAP);
   assign ph_after_addr = mode_en_q ? PH_MODE : ph_after_mode;

   always_comb begin
      case (ph)
         PH_OPC:   ph_nxt = PH_ADDR;
         PH_ADDR:  ph_nxt = ph_after_addr;
         PH_MODE:  ph_nxt = ph_after_mode;
         PH_DUMMY: ph_nxt = is_mem ? PH_DATA : PH_GAP;
         PH_DATA:  ph_nxt = PH_GAP;
         default:  ph_nxt = PH_IDLE;
      endcase
   end

   assign last     = half && (cnt == len - CNT_W'(1));
   assign raw_next = {dat, io_in};

   for (genvar i = 0; i < DATA_W / 8; i++) begin : g_byte
      if (LITTLE_END) begin : g_le
         assign ordered[8*i +: 8] = raw_next[DATA_W-8-8*i +: 8];
      end else begin : g_be
         assign ordered[8*i +: 8] = raw_next[8*i +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         half      <= 1'b0;
         cnt       <= '0;
         is_mem    <= 1'b0;
         addr4_q   <= 1'b0;
         mode_en_q <= 1'b0;
         opc_sh    <= '0;
         adr_sh    <= '0;
         mod_sh    <= '0;
         dat       <= '0;
         mem_ready <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ready <= 1'b0;
         case (ph)
            PH_IDLE: if (go_cmd || go_mem) begin
               is_mem    <= !go_cmd;
               addr4_q   <= st_fmt.addr4;
               mode_en_q <= st_fmt.mode_en;
               opc_sh    <= st_fmt.opc;
               adr_sh    <= st_fmt.addr4 ? st_addr : {st_addr[23:0], 8'h00};
               mod_sh    <= mode_byte;
               ph        <= st_fmt.no_opc ? PH_ADDR : PH_OPC;
               half      <= 1'b0;
               cnt       <= '0;
            end
            PH_GAP: begin
               half <= !half;
               if (half) ph <= PH_IDLE;
            end
            default: begin
               if (abort) begin
                  ph   <= PH_GAP;
                  half <= 1'b0;
                  cnt  <= '0;
               end else begin
                  half <= !half;
                  if (half) begin
                     case (ph)
                        PH_OPC:  opc_sh <= {opc_sh[6:0], 1'b0};
                        PH_ADDR: adr_sh <= {adr_sh[27:0], 4'h0};
                        PH_MODE: mod_sh <= {mod_sh[3:0], 4'h0};
                        PH_DATA: dat    <= raw_next[DATA_W-5:0];
                        default: ;
                     endcase
                     if (last) begin
                        cnt <= '0;
                        ph  <= ph_nxt;
                        if (ph == PH_DATA) begin
                           mem_ready <= 1'b1;
                           mem_rdata <= ordered;
                        end
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
               end
            end
         endcase
      end
   end

   assign act     = (ph != PH_IDLE) && (ph != PH_GAP);
   assign cs_n    = !act;
   assign sck     = act && half;
   assign busy    = (ph != PH_IDLE);
   assign cmd_act = busy && !is_mem;

   always_comb begin
      io_out = 4'h0;
      io_oe  = 4'h0;
      case (ph)
         PH_OPC:  begin io_out = {3'b000, opc_sh[7]}; io_oe = 4'b0001; end
         PH_ADDR: begin io_out = adr_sh[31:28];       io_oe = 4'b1111; end
         PH_MODE: begin io_out = mod_sh[7:4];         io_oe = 4'b1111; end
         default: ;
      endcase
   end

   AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck) else $error("sck while deselected"); // R8
   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n) else $error("short deselect"); // R8
   AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !cs_n) |=> cs_n) else $error("abort kept select"); // R10
   AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ready |=> !mem_ready) else $error("ready not a pulse"); // R6
   AST_RDY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ready |-> cs_n) else $error("ready during frame"); // R7
endmodule

// File: rtl/qspi_xip_rd.sv
module qspi_xip_rd
   import qxr_pkg::*;
#(
   parameter int DUMMY_W    = 4,
   parameter int DATA_W     = 32,
   parameter bit LITTLE_END = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              mem_req,
   input  logic [31:0]       mem_addr,
   output logic [DATA_W-1:0] mem_rdata,
   output logic              mem_ready,
   output logic              sck,
   output logic              cs_n,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_in
);
   if (DATA_W % 8 != 0 || DATA_W < 8 || DATA_W > 64) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 8 between 8 and 64");
   end
   if (DUMMY_W < 1 || DUMMY_W > 8) begin : g_bad_dummy_w
      $error("DUMMY_W must lie between 1 and 8");
   end

   logic               seq_busy, seq_cmd_act, cmd_go, cmd_wait, mem_mode, abort, mem_go;
   qxr_fmt_t           cmd_fmt, mem_fmt;
   logic [31:0]        cmd_addr;
   logic [7:0]         mode_byte;
   logic [DUMMY_W-1:0] dummy;

   qxr_regs #(.DUMMY_W(DUMMY_W)) u_regs (
      .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
      .seq_busy, .seq_cmd_act, .cmd_go, .cmd_wait, .cmd_fmt, .mem_fmt,
      .cmd_addr, .mode_byte, .dummy, .mem_mode, .abort
   );

   assign mem_go = mem_mode && mem_req && !cmd_wait && !abort;

   qxr_seq #(.DUMMY_W(DUMMY_W), .DATA_W(DATA_W), .LITTLE_END(LITTLE_END)) u_seq (
      .clk, .rst_n, .go_cmd(cmd_go), .go_mem(mem_go), .cmd_fmt, .mem_fmt,
      .cmd_addr, .mem_addr, .mode_byte, .dummy, .abort, .io_in,
      .busy(seq_busy), .cmd_act(seq_cmd_act), .mem_ready, .mem_rdata,
      .sck, .cs_n, .io_out, .io_oe
   );
endmodule

// File: tb/qspi_xip_rd_bench.sv
`timescale 1ns/1ps
module qspi_xip_rd_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req = 1'b0;
   logic [31:0] mem_addr = '0;
   logic [31:0] mem_rdata;
   logic        mem_ready, sck, cs_n;
   logic [3:0]  io_out, io_oe;
   logic [3:0]  io_in = 4'h0;

   always #4 clk = !clk;

   qspi_xip_rd u_qspi_xip_rd (
      .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
      .mem_req, .mem_addr, .mem_rdata, .mem_ready,
      .sck, .cs_n, .io_out, .io_oe, .io_in
   );

   int n_chk = 0, n_fail = 0;

   // ---------------- behavioural flash ----------------
   bit   g_addr4 = 0, g_mode_en = 1;
   int   g_dummy = 4;
   bit   cont = 0, has_opc = 0;
   int   idx = 0, f_frames = 0, f_len = 0;
   logic [7:0]  opc_rx, mode_rx, f_opc, f_mode;
   logic [31:0] addr_rx, f_addr;
   bit   f_had_opc = 0;
   logic p_cs = 1'b1, p_sck = 1'b0;
   int   oe_bad = 0;

   function automatic logic [7:0] fbyte(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction
   function automatic logic [31:0] fword(input logic [31:0] a);
      return {fbyte(a + 3), fbyte(a + 2), fbyte(a + 1), fbyte(a)};
   endfunction
   function automatic int o_addr(); return has_opc ? 8 : 0; endfunction
   function automatic int o_mode(); return o_addr() + (g_addr4 ? 8 : 6); endfunction
   function automatic int o_dum();  return o_mode() + (g_mode_en ? 2 : 0); endfunction
   function automatic int o_dat();  return o_dum() + g_dummy; endfunction

   always @(cs_n, sck) begin
      if (cs_n !== p_cs) begin
         if (!cs_n) begin
            idx = 0; has_opc = !cont; opc_rx = 0; addr_rx = 0; mode_rx = 0;
         end else if (p_cs === 1'b0) begin
            f_frames++; f_len = idx; f_opc = opc_rx; f_addr = addr_rx;
            f_mode = mode_rx; f_had_opc = has_opc;
            cont = g_mode_en && (idx >= o_dum()) && (mode_rx == 8'hA5);
         end
      end else if (!cs_n && sck && !p_sck) begin
         if (idx < o_addr()) begin
            opc_rx = {opc_rx[6:0], io_out[0]};
            if (io_oe !== 4'b0001) oe_bad++;
         end else if (idx < o_mode()) begin
            addr_rx = {addr_rx[27:0], io_out};
            if (io_oe !== 4'b1111) oe_bad++;
         end else if (idx < o_dum()) begin
            mode_rx = {mode_rx[3:0], io_out};
            if (io_oe !== 4'b1111) oe_bad++;
         end else if (io_oe !== 4'b0000) oe_bad++;
         idx++;
      end else if (!cs_n && !sck && p_sck) begin
         if (idx >= o_dat()) begin
            automatic int k = idx - o_dat();
            automatic logic [7:0] b = fbyte(addr_rx + 32'(k / 2));
            io_in = (k % 2 == 0) ? b[7:4] : b[3:0];
         end
      end
      p_cs = cs_n; p_sck = sck;
   end

   // ---------------- per-clock pin monitor ----------------
   int gap = 0, mon_fail = 0;
   bit seen_frame = 0;
   always @(negedge clk) if (rst_n) begin
      if (cs_n && sck) mon_fail++;
      if (mem_ready && !cs_n) mon_fail++;
      if (cs_n) gap++;
      else begin
         if (seen_frame && gap > 0 && gap < 2) mon_fail++;
         gap = 0; seen_frame = 1;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [31:0] v);
      reg_sel = s; #1; v = reg_rdata;
   endtask

   task automatic wait_cmd_done();
      logic [31:0] st;
      for (int i = 0; i < 2000; i++) begin
         rd(3'd5, st);
         if (!st[1]) break;
         @(negedge clk);
      end
   endtask

   task automatic mem_read(input logic [31:0] a, output logic [31:0] d, output int cyc);
      @(negedge clk); mem_req = 1'b1; mem_addr = a; cyc = 0;
      while (!mem_ready && cyc < 5000) begin @(negedge clk); cyc++; end
      d = mem_rdata; mem_req = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic run();
      logic [31:0] st, d;
      int cyc, base, rdy_seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(3'd5, st);
      chk("R6 status after reset", st, 32'h0);
      chk("R8 idle pins", {cs_n, sck, mem_ready, io_oe}, {1'b1, 1'b0, 1'b0, 4'h0});

      // plain opcode reads, 3-byte address, dummy 4
      g_addr4 = 0; g_mode_en = 1; g_dummy = 4;
      wr(3'd2, 32'd4); wr(3'd1, 32'h00); wr(3'd4, 32'h4EB);
      rd(3'd5, st);
      chk("R6 memory mode flag", st[0], 1'b1);
      mem_read(32'h0000_0123, d, cyc);
      chk("R6 little-endian data", d, fword(32'h123));
      chk("R1 opcode on line 0", f_opc, 8'hEB);
      chk("R2 3-byte address", f_addr, 32'h123);
      chk("R4 intermediate byte", f_mode, 8'h00);
      chk("R1 frame length", f_len, 28);
      chk("R7 ready waits for frame", cyc >= 56, 1'b1);

      // priming for opcode-less reads, 4-byte address
      g_addr4 = 1;
      wr(3'd1, 32'hA5); wr(3'd0, 32'h0); wr(3'd3, 32'h5EC);
      rd(3'd5, st);
      chk("R5 command busy flag", st[1], 1'b1);
      chk("R9 command write leaves memory mode", st[0], 1'b0);
      wait_cmd_done();
      chk("R5 command opcode", f_opc, 8'hEC);
      chk("R5 command frame without data", f_len, 22);
      chk("R11 flash primed", cont, 1'b1);
      wr(3'd4, 32'h7EC);
      mem_read(32'h0000_1000, d, cyc);
      chk("R11 opcode-less read data", d, fword(32'h1000));
      chk("R3 no opcode phase", f_had_opc, 1'b0);
      chk("R3 frame 8 clocks shorter", f_len, 30 - 8);
      mem_read(32'h00AB_CDE0, d, cyc);
      chk("R11 second opcode-less read", d, fword(32'h00ABCDE0));
      chk("R2 4-byte address", f_addr, 32'h00AB_CDE0);

      // reset request aborts a running frame
      @(negedge clk); mem_req = 1'b1; mem_addr = 32'h0000_3000;
      repeat (10) @(negedge clk);
      chk("R10 frame running before reset", cs_n, 1'b0);
      wr(3'd5, 32'h10);
      rd(3'd5, st);
      chk("R10 request bit held", st[4], 1'b1);
      rdy_seen = 0;
      @(negedge clk);
      chk("R10 select released", cs_n, 1'b1);
      mem_req = 1'b0;
      for (int i = 0; i < 100; i++) begin
         if (mem_ready) rdy_seen++;
         rd(3'd5, st);
         if (!st[4]) break;
         @(negedge clk);
      end
      chk("R10 status after reset", st & 32'h13, 32'h0);
      chk("R10 aborted read not completed", rdy_seen, 0);

      // command write during a memory frame (opcode mode)
      wr(3'd1, 32'h00); wr(3'd4, 32'h5EC);
      base = f_frames;
      fork
         mem_read(32'h0000_2040, d, cyc);
         begin repeat (10) @(negedge clk); wr(3'd3, 32'h5EC); end
      join
      chk("R9 running frame completes", d, fword(32'h2040));
      wait_cmd_done();
      chk("R9 command frame follows", f_frames, base + 2);
      chk("R9 command opcode sent", f_opc, 8'hEC);
      rd(3'd5, st);
      chk("R9 memory mode cleared", st[0], 1'b0);

      // no intermediate byte, zero dummy clocks
      g_mode_en = 0; g_dummy = 0;
      wr(3'd2, 32'd0); wr(3'd4, 32'h1EB);
      mem_read(32'h0055_AA00, d, cyc);
      chk("R4 zero dummy read data", d, fword(32'h0055AA00));
      chk("R4 frame length without mode and dummy", f_len, 24);

      repeat (4) @(negedge clk);
      chk("R8 per-clock pin monitor", mon_fail, 0);
      chk("R1 output enables per phase", oe_bad, 0);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog act=hung exp=finished");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule